// File: doc/BRIEF.md
# Multi-Mode Local Interrupt Timer

This block is a local interrupt timer for one processing element. Software programs a control word (interrupt vector, mask and a two-bit mode), an initial count and an absolute deadline target. Three modes are available. The one-shot countdown decrements the initial count once, down to zero. The periodic countdown reloads the initial count after each zero and repeats. The deadline mode compares a free-running timestamp input against an absolute target. The fourth mode encoding is reserved and keeps the timer idle.

Each expiry is an edge event. It yields a single one-cycle request on `irq_pulse`, and the programmed vector is presented on `irq_vector`. A masked expiry is discarded and leaves nothing pending. The countdown advances only in cycles where `tick_en` is high, so an external prescaler can slow it down. The current count is always visible for readback. A control write whose vector falls in the reserved range 0 to 15 raises the illegal-vector flag.

Top module: `tmr_local`

## Requirements
- R1: After reset `cur_count` is 0, `irq_pulse` is 0, `vec_err` is 0, `irq_vector` is 0, the mode is one-shot and the mask is set, so a countdown started before any control write expires without a request.
- R2: In one-shot mode (mode field 00), once an initial count N is written, the count decrements on each cycle with `tick_en` high. `irq_pulse` is high for exactly one cycle, the cycle in which `cur_count` first reads 0. The count then stays at 0 with no further requests until a new initial count is written.
- R3: In cycles where `tick_en` is low, a running countdown holds its value.
- R4: In periodic mode (mode field 01), the cycle after the count reaches zero, the initial count is reloaded whether or not `tick_en` is high. Every pass through zero gives one request.
- R5: In deadline mode (mode field 10), a single request fires when `timestamp` is greater than or equal to a nonzero target, and firing clears the target. Writing a target of 0 disarms the timer.
- R6: Writing an initial count of 0 stops either countdown mode at 0 without a request.
- R7: The reserved mode (mode field 11) holds the count and raises no request.
- R8: While the mask bit is 1, an expiry raises no request. Clearing the mask later does not bring that expiry back.
- R9: A control write with a vector of 0 to 15 sets `vec_err`, and a control write with a vector of 16 or more clears it. `irq_vector` always shows the stored vector.
- R10: A register write always takes priority over an expiry in the same cycle. An initial-count write that lands on the final tick loads the new count with no request. A target write that lands on a deadline match loads the new target with no request.
- R11: `wr_sel` codes: 0 is the control word, 1 is the initial count, 2 is the deadline target, 3 writes nothing. Control word fields: vector in bits 7:0, mask in bit 16, mode in bits 18:17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Countdown advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | TS_W | Write data |
| timestamp | input | TS_W | Free-running timestamp for deadline compare |
| cur_count | output | CNT_W | Current countdown value |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Programmed interrupt vector |
| vec_err | output | 1 | Illegal-vector flag |

## Verification
Two events can fall in the same clock cycle: a register write and an expiry. The bench provokes this twice. First, it writes a fresh initial count in the exact cycle where the count is at 1 and `tick_en` is high. Second, it rewrites the deadline target in the cycle where the old target already matches the timestamp. In both cases it expects the write to win, with no pulse at that edge. In the deadline case it then expects a single pulse one cycle later, against the new target.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Mode field encoding (control word bits 18:17)
   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'b00,
      MODE_PERIODIC = 2'b01,
      MODE_DEADLINE = 2'b10,
      MODE_RSVD     = 2'b11
   } tmr_mode_e;

   // Register select codes
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_INIT = 2'd1,
      SEL_TGT  = 2'd2,
      SEL_NONE = 2'd3
   } tmr_sel_e;

   // Control word field positions
   localparam int unsigned CTL_MASK_BIT = 16;
   localparam int unsigned CTL_MODE_LSB = 17;

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
   import tmr_pkg::*;
#(
   parameter int unsigned VEC_W             = 8,
   parameter int unsigned ILLEGAL_VEC_LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [VEC_W-1:0] vec_in,
   input  logic             mask_in,
   input  logic [1:0]       mode_in,
   output logic [VEC_W-1:0] vec_q,
   output logic             mask_q,
   output tmr_mode_e        mode_q,
   output logic             vec_err_q
);

   localparam logic [VEC_W-1:0] VEC_LIM = VEC_W'(ILLEGAL_VEC_LIMIT);

   logic vec_bad;

   assign vec_bad = (vec_in < VEC_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q     <= '0;
         mask_q    <= 1'b1;
         mode_q    <= MODE_ONESHOT;
         vec_err_q <= 1'b0;
      end else if (ctl_wr) begin
         vec_q     <= vec_in;
         mask_q    <= mask_in;
         mode_q    <= tmr_mode_e'(mode_in);
         vec_err_q <= vec_bad;
      end
   end

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run_en,
   input  logic             periodic,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count_q,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] init_q;
   logic             cnt_zero;
   logic             dec;
   logic             reload;

   assign cnt_zero = (count_q == '0);
   // a write always wins over a decrement or a reload
   assign dec      = run_en && tick_en && !cnt_zero && !load;
   assign expire   = dec && (count_q == ONE);
   assign reload   = run_en && periodic && cnt_zero && (init_q != '0) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         init_q  <= '0;
      end else if (load) begin
         count_q <= load_val;
         init_q  <= load_val;
      end else if (dec) begin
         count_q <= count_q - ONE;
      end else if (reload) begin
         count_q <= init_q;
      end
   end

endmodule

// File: rtl/tmr_deadline.sv
module tmr_deadline #(
   parameter int unsigned TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            tgt_wr,
   input  logic [TS_W-1:0] tgt_val,
   input  logic [TS_W-1:0] timestamp,
   output logic            expire
);

   logic [TS_W-1:0] tgt_q;
   logic            armed;

   assign armed  = (tgt_q != '0);
   assign expire = active && armed && !tgt_wr && (timestamp >= tgt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= '0;
      end else if (tgt_wr) begin
         tgt_q <= tgt_val;
      end else if (expire) begin
         tgt_q <= '0;
      end
   end

endmodule

// File: rtl/tmr_local.sv
module tmr_local
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W             = 32,
   parameter int unsigned TS_W              = 64,
   parameter int unsigned VEC_W             = 8,
   parameter int unsigned ILLEGAL_VEC_LIMIT = 16,
   parameter bit          HAS_DEADLINE      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [TS_W-1:0]  wr_data,
   input  logic [TS_W-1:0]  timestamp,
   output logic [CNT_W-1:0] cur_count,
   output logic             irq_pulse,
   output logic [VEC_W-1:0] irq_vector,
   output logic             vec_err
);

   localparam int unsigned MODE_MSB = CTL_MODE_LSB + 1;

   generate
      if (CNT_W < 2 || TS_W <= MODE_MSB || TS_W < CNT_W ||
          VEC_W < 5 || VEC_W > CTL_MASK_BIT ||
          ILLEGAL_VEC_LIMIT >= (1 << VEC_W)) begin : g_bad_cfg
         $error("tmr_local: illegal parameter combination");
      end
   endgenerate

   logic      wr_ctl, wr_init, wr_tgt;
   logic      ctl_mask;
   tmr_mode_e ctl_mode;
   logic      cd_run, cd_periodic, cd_expire;
   logic      dl_expire;
   logic      irq_q;

   assign wr_ctl  = wr_en && (wr_sel == SEL_CTRL);
   assign wr_init = wr_en && (wr_sel == SEL_INIT);
   assign wr_tgt  = wr_en && (wr_sel == SEL_TGT);

   tmr_ctrl_regs #(
      .VEC_W            (VEC_W),
      .ILLEGAL_VEC_LIMIT(ILLEGAL_VEC_LIMIT)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (wr_ctl),
      .vec_in   (wr_data[VEC_W-1:0]),
      .mask_in  (wr_data[CTL_MASK_BIT]),
      .mode_in  (wr_data[MODE_MSB:CTL_MODE_LSB]),
      .vec_q    (irq_vector),
      .mask_q   (ctl_mask),
      .mode_q   (ctl_mode),
      .vec_err_q(vec_err)
   );

   assign cd_run      = (ctl_mode == MODE_ONESHOT) || (ctl_mode == MODE_PERIODIC);
   assign cd_periodic = (ctl_mode == MODE_PERIODIC);

   tmr_countdown #(
      .CNT_W(CNT_W)
   ) i_cd (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .run_en  (cd_run),
      .periodic(cd_periodic),
      .load    (wr_init),
      .load_val(wr_data[CNT_W-1:0]),
      .count_q (cur_count),
      .expire  (cd_expire)
   );

   generate
      if (HAS_DEADLINE) begin : g_dl
         tmr_deadline #(
            .TS_W(TS_W)
         ) i_dl (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (ctl_mode == MODE_DEADLINE),
            .tgt_wr   (wr_tgt),
            .tgt_val  (wr_data),
            .timestamp(timestamp),
            .expire   (dl_expire)
         );
      end else begin : g_no_dl
         // deadline mode degrades to idle
         assign dl_expire = 1'b0;
      end
   endgenerate

   // edge request: one cycle per expiry, dropped outright when masked
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= (cd_expire || dl_expire) && !ctl_mask;
      end
   end

   assign irq_pulse = irq_q;

endmodule

// File: rtl/tmr_local_chk.sv
module tmr_local_chk #(
   parameter int unsigned CNT_W             = 32,
   parameter int unsigned VEC_W             = 8,
   parameter int unsigned ILLEGAL_VEC_LIMIT = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [VEC_W-1:0] wr_vec,
   input logic [CNT_W-1:0] cur_count,
   input logic             irq_pulse,
   input logic             vec_err,
   input logic [1:0]       mode_q,
   input logic             mask_q
);

   localparam logic [VEC_W-1:0] LIM = VEC_W'(ILLEGAL_VEC_LIMIT);

   // R2: the request is a single-cycle pulse
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   // R2: a countdown request coincides with a zero count
   a_r2_zero_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse && !$past(mode_q[1])) |-> (cur_count == '0));

   // R3: one-shot count holds without tick or write
   a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 && !tick_en && !wr_en) |=> $stable(cur_count));

   // R7: reserved mode never requests
   a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ($past(mode_q) != 2'b11));

   // R8: masked timer never requests
   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !$past(mask_q));

   // R9: error flag follows the vector of the last control write
   a_r9_vec_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (vec_err == ($past(wr_vec) < LIM)));

endmodule

bind tmr_local tmr_local_chk #(
   .CNT_W            (CNT_W),
   .VEC_W            (VEC_W),
   .ILLEGAL_VEC_LIMIT(ILLEGAL_VEC_LIMIT)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_vec   (wr_data[VEC_W-1:0]),
   .cur_count(cur_count),
   .irq_pulse(irq_pulse),
   .vec_err  (vec_err),
   .mode_q   (ctl_mode),
   .mask_q   (ctl_mask)
);

// File: tb/test_tmr_local.sv
module test_tmr_local;

   localparam int CNT_W = 32;
   localparam int TS_W  = 64;
   localparam int VEC_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b1;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_sel = 2'd3;
   logic [TS_W-1:0]  wr_data = '0;
   logic [TS_W-1:0]  ts = '0;
   logic [CNT_W-1:0] cur_count;
   logic             irq_pulse;
   logic [VEC_W-1:0] irq_vector;
   logic             vec_err;

   int n_vec = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   tmr_local i_tmr_local (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .timestamp (ts),
      .cur_count (cur_count),
      .irq_pulse (irq_pulse),
      .irq_vector(irq_vector),
      .vec_err   (vec_err)
   );

   typedef struct packed {
      logic        do_wr;
      logic [1:0]  sel;
      logic [31:0] data;
      logic [7:0]  wait_n;
      logic [31:0] exp_cnt;
      logic [3:0]  exp_p;
   } vec_t;

   localparam int NV = 19;
   // sel 0 ctrl (vector 7:0, mask 16, mode 18:17), 1 init count, 2 target
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd0, 32'h0000_0040, 8'd0,  32'd0, 4'd0},  // R11 one-shot, unmasked
      '{1'b1, 2'd1, 32'd5,         8'd0,  32'd5, 4'd0},  // R2 load
      '{1'b0, 2'd3, 32'd0,         8'd3,  32'd2, 4'd0},  // R2 decrement
      '{1'b0, 2'd3, 32'd0,         8'd2,  32'd0, 4'd1},  // R2 expiry
      '{1'b0, 2'd3, 32'd0,         8'd4,  32'd0, 4'd0},  // R2 stays at zero
      '{1'b1, 2'd0, 32'h0002_0040, 8'd0,  32'd0, 4'd0},  // R4 periodic
      '{1'b0, 2'd3, 32'd0,         8'd1,  32'd5, 4'd0},  // R4 reload
      '{1'b0, 2'd3, 32'd0,         8'd5,  32'd0, 4'd1},  // R4 first pass
      '{1'b0, 2'd3, 32'd0,         8'd1,  32'd5, 4'd0},  // R4 reload again
      '{1'b0, 2'd3, 32'd0,         8'd12, 32'd5, 4'd2},  // R4 two periods
      '{1'b1, 2'd1, 32'd0,         8'd0,  32'd0, 4'd0},  // R6 zero count
      '{1'b0, 2'd3, 32'd0,         8'd6,  32'd0, 4'd0},  // R6 stopped
      '{1'b1, 2'd0, 32'h0006_0040, 8'd0,  32'd0, 4'd0},  // R7 reserved
      '{1'b1, 2'd1, 32'd3,         8'd0,  32'd3, 4'd0},  // R7 load
      '{1'b0, 2'd3, 32'd0,         8'd6,  32'd3, 4'd0},  // R7 holds
      '{1'b1, 2'd0, 32'h0001_0040, 8'd0,  32'd3, 4'd0},  // R8 masked one-shot
      '{1'b0, 2'd3, 32'd0,         8'd3,  32'd0, 4'd0},  // R8 masked expiry
      '{1'b1, 2'd0, 32'h0000_0040, 8'd0,  32'd0, 4'd0},  // R8 unmask
      '{1'b0, 2'd3, 32'd0,         8'd4,  32'd0, 4'd0}   // R8 nothing pending
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq_pulse) pulses++;
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [63:0] data);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      run(1);
      wr_en   = 1'b0;
      wr_sel  = 2'd3;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", 64'(cur_count), 64'd0);
      chk("R1 irq", 64'(irq_pulse), 64'd0);
      chk("R1 vec_err", 64'(vec_err), 64'd0);
      chk("R1 vector", 64'(irq_vector), 64'd0);
      pulses = 0;
      wr(2'd1, 64'd2);
      run(4);
      chk("R1 masked default", 64'(pulses), 64'd0);
      chk("R1 count at zero", 64'(cur_count), 64'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         pulses = 0;
         if (VECS[v].do_wr) wr(VECS[v].sel, 64'(VECS[v].data));
         run(int'(VECS[v].wait_n));
         n_vec++;
         if (cur_count !== VECS[v].exp_cnt || pulses != int'(VECS[v].exp_p)) begin
            n_bad++;
            $display("FAIL vector %0d (R2..R8,R11): actual count %0d pulses %0d expected count %0d pulses %0d",
                     v, cur_count, pulses, VECS[v].exp_cnt, VECS[v].exp_p);
         end
      end

      // R3 tick gating
      tick_en = 1'b0;
      wr(2'd1, 64'd4);
      run(5);
      chk("R3 hold", 64'(cur_count), 64'd4);
      tick_en = 1'b1;
      run(2);
      chk("R3 resume", 64'(cur_count), 64'd2);

      // R10 init write on the final tick
      run(1);
      chk("R10 count at one", 64'(cur_count), 64'd1);
      pulses = 0;
      wr(2'd1, 64'd7);
      chk("R10 write wins count", 64'(cur_count), 64'd7);
      chk("R10 write wins pulse", 64'(pulses), 64'd0);
      run(7);
      chk("R10 later expiry", 64'(pulses), 64'd1);

      // R9 vector error
      wr(2'd0, 64'h0F);
      chk("R9 err set", 64'(vec_err), 64'd1);
      chk("R9 vector", 64'(irq_vector), 64'h0F);
      wr(2'd0, 64'h10);
      chk("R9 err clear", 64'(vec_err), 64'd0);

      // R5 deadline
      wr(2'd0, 64'h4_0055);
      ts = 64'd100;
      pulses = 0;
      wr(2'd2, 64'd150);
      ts = 64'd149;
      run(2);
      chk("R5 before target", 64'(pulses), 64'd0);
      ts = 64'd150;
      run(1);
      chk("R5 fires at target", 64'(pulses), 64'd1);
      chk("R5 vector", 64'(irq_vector), 64'h55);
      ts = 64'd200;
      pulses = 0;
      run(3);
      chk("R5 target cleared", 64'(pulses), 64'd0);
      wr(2'd2, 64'd0);
      ts = 64'd300;
      run(3);
      chk("R5 zero disarms", 64'(pulses), 64'd0);
      wr(2'd2, 64'd50);
      chk("R5 past target write", 64'(pulses), 64'd0);
      run(1);
      chk("R5 past target fires", 64'(pulses), 64'd1);

      // R10 target write on a match
      pulses = 0;
      wr(2'd2, 64'd10);
      wr(2'd2, 64'd20);
      chk("R10 target write wins", 64'(pulses), 64'd0);
      run(1);
      chk("R10 new target fires", 64'(pulses), 64'd1);

      // R8 masked deadline leaves nothing pending
      pulses = 0;
      wr(2'd0, 64'h5_0055);
      wr(2'd2, 64'd250);
      run(2);
      wr(2'd0, 64'h4_0055);
      run(3);
      chk("R8 masked deadline", 64'(pulses), 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule